// File: doc/BRIEF.md
# Configurable Endianness Bus Adapter

This block connects a processor load/store port to a 32-bit memory bus whose byte lanes are numbered big-endian. It applies one of three byte orderings. In big-endian order the most significant byte of a scalar sits at the lowest address. In true little-endian order the least significant byte sits at the lowest address, and memory really holds the bytes that way. In munged little-endian order memory stays big-endian and only the low three address bits are rewritten, so the processor sees a little-endian layout.

Each request carries an address, a size, a read/write flag and right-justified write data. The adapter checks alignment first. It then computes the bus address, the lane enables and the lane-placed write data, and registers them into a single bus cycle that is held until the bus accepts it. Read data coming back is put into processor order, right-justified and zero-extended. The ordering mode is captured when a request is accepted, so changing the mode input during a transfer has no effect on that transfer.

Top module: `endian_bus_adapter`

## Requirements
- R1: `mode_i` selects the ordering: 2'b00 big-endian, 2'b01 true little-endian, 2'b10 munged little-endian. The reserved code 2'b11 behaves as big-endian. `size_i` encodes 2'b00 byte, 2'b01 halfword, 2'b10 word.
- R2: In big-endian mode the bus address equals the request address. Lane k (k = address offset within the word) carries bus bits [31-8k -: 8], and the most significant byte of the value goes to the lowest lane of the accessed unit.
- R3: In true little-endian mode the bus address equals the request address. The least significant byte of the value sits at the lowest lane of the accessed unit. For example, a word 0xAABBCCDD is written as bus data 0xDDCCBBAA, and a halfword 0x1234 at offset 2 is written as 0x00003412 with enables 4'b1100.
- R4: In munged mode the low three address bits are XORed with 3'b111 for a byte, 3'b110 for a halfword and 3'b100 for a word. Data placement uses big-endian order at the modified address.
- R5: `bus_be_o` bit k enables lane k. A byte access enables one lane, a halfword two adjacent lanes, and a word all four.
- R6: Read data is returned on `rsp_rdata_o` in processor order, right-justified, with all bits above the access size zero. A write response returns zero.
- R7: A halfword with address bit 0 set, a word with either of address bits 1:0 set, or size code 2'b11 produces a one-cycle `align_err_o` pulse in the cycle after acceptance, and no bus cycle is issued.
- R8: The mode is captured when a request is accepted. A change of `mode_i` while a transfer is pending does not alter that transfer's address, enables, write data or read-data ordering.
- R9: `req_ready_o` is high only when no transfer is pending. `bus_valid_o` rises in the cycle after acceptance. Address, enables and write data stay stable while `bus_ready_i` is low. `rsp_valid_o` pulses in the cycle after the bus handshake.
- R10: After reset, `req_ready_o` is 1 and `bus_valid_o`, `rsp_valid_o` and `align_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Byte-ordering mode select |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Adapter idle, request will be accepted |
| req_addr_i | input | ADDR_W | Processor byte address |
| req_size_i | input | 2 | Access size code |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 32 | Right-justified write data |
| rsp_valid_o | output | 1 | Completion pulse |
| rsp_rdata_o | output | 32 | Corrected, zero-extended read data |
| align_err_o | output | 1 | Misaligned or invalid-size request pulse |
| bus_valid_o | output | 1 | Bus cycle pending |
| bus_ready_i | input | 1 | Bus accepts the cycle |
| bus_addr_o | output | ADDR_W | Modified bus byte address |
| bus_be_o | output | 4 | Lane enables, bit k = lane k |
| bus_we_o | output | 1 | Bus write flag |
| bus_wdata_o | output | 32 | Lane-placed write data |
| bus_rdata_i | input | 32 | Bus read data |

## Verification
A word is written in one mode and read back as single bytes, halfwords and whole words in the same mode and in big-endian mode. A pure address transform and a true lane reversal give different bus addresses and data for this pattern. The bus address of the same munged access shows that memory keeps big-endian order, while the raw bus data of a true little-endian write shows that the bytes were physically swapped. Misaligned halfword and word addresses, together with the invalid size code, exercise the error path. A read that stalls while the mode input flips separates a design that latches the mode from one that follows the live input.

// File: rtl/endian_pkg.sv
package endian_pkg;

  typedef enum logic [1:0] {
    ORD_BIG     = 2'b00,
    ORD_TRUE_LE = 2'b01,
    ORD_MUNGED  = 2'b10,
    ORD_RSVD    = 2'b11
  } order_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } size_e;

  localparam int unsigned BUS_W   = 32;
  localparam int unsigned LANES   = BUS_W / 8;
  localparam int unsigned LANE_AW = $clog2(LANES);

  // XOR pattern for the doubleword-granular address rewrite
  function automatic logic [2:0] munge_mask(input size_e s);
    case (s)
      SZ_BYTE: munge_mask = 3'b111;
      SZ_HALF: munge_mask = 3'b110;
      SZ_WORD: munge_mask = 3'b100;
      default: munge_mask = 3'b000;
    endcase
  endfunction

  // XOR pattern that gives core-order lane offset in true LE mode
  function automatic logic [1:0] swap_mask(input size_e s);
    case (s)
      SZ_BYTE: swap_mask = 2'b11;
      SZ_HALF: swap_mask = 2'b10;
      default: swap_mask = 2'b00;
    endcase
  endfunction

  function automatic logic misaligned(input size_e s, input logic [1:0] a);
    case (s)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = a[0];
      SZ_WORD: misaligned = |a;
      default: misaligned = 1'b1;
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_enables(input size_e s, input logic [1:0] off);
    case (s)
      SZ_BYTE: lane_enables = 4'b0001 << off;
      SZ_HALF: lane_enables = off[1] ? 4'b1100 : 4'b0011;
      SZ_WORD: lane_enables = 4'b1111;
      default: lane_enables = 4'b0000;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] mirror_bytes(input logic [BUS_W-1:0] x);
    mirror_bytes = {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [LANES-1:0] mirror_lanes(input logic [LANES-1:0] e);
    mirror_lanes = {e[0], e[1], e[2], e[3]};
  endfunction

  // Big-endian placement of a right-justified value at lane offset 'off'
  function automatic logic [BUS_W-1:0] place_msb_first(input logic [BUS_W-1:0] d,
                                                      input size_e s, input logic [1:0] off);
    case (s)
      SZ_BYTE: place_msb_first = {d[7:0], 24'h0} >> {off, 3'b000};
      SZ_HALF: place_msb_first = {d[15:0], 16'h0} >> {off, 3'b000};
      default: place_msb_first = d;
    endcase
  endfunction

  // Inverse of place_msb_first, result right-justified and zero-extended
  function automatic logic [BUS_W-1:0] pick_msb_first(input logic [BUS_W-1:0] lanes,
                                                     input size_e s, input logic [1:0] off);
    logic [BUS_W-1:0] shl;
    shl = lanes << {off, 3'b000};
    case (s)
      SZ_BYTE: pick_msb_first = {24'h0, shl[31:24]};
      SZ_HALF: pick_msb_first = {16'h0, shl[31:16]};
      default: pick_msb_first = lanes;
    endcase
  endfunction

endpackage

// File: rtl/endian_addr_map.sv
module endian_addr_map
  import endian_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  size_e             size_i,
  input  order_e            mode_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        lane_off_o,
  output logic              misalign_o
);

  always_comb begin
    misalign_o = misaligned(size_i, addr_i[1:0]);
    bus_addr_o = addr_i;
    lane_off_o = addr_i[1:0];
    case (mode_i)
      ORD_MUNGED: begin
        bus_addr_o[2:0] = addr_i[2:0] ^ munge_mask(size_i);
        lane_off_o      = addr_i[1:0] ^ munge_mask(size_i)[1:0];
      end
      ORD_TRUE_LE: begin
        // lanes are chosen in core order, the lane mirror undoes the rewrite on the bus
        lane_off_o = addr_i[1:0] ^ swap_mask(size_i);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/endian_wr_lanes.sv
module endian_wr_lanes
  import endian_pkg::*;
(
  input  order_e           mode_i,
  input  size_e            size_i,
  input  logic [1:0]       lane_off_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [LANES-1:0] be_o,
  output logic [BUS_W-1:0] bus_wdata_o
);

  logic             swap;
  logic [LANES-1:0] core_be;
  logic [BUS_W-1:0] core_data;

  always_comb begin
    swap        = (mode_i == ORD_TRUE_LE);
    core_be     = lane_enables(size_i, lane_off_i);
    core_data   = place_msb_first(wdata_i, size_i, lane_off_i);
    be_o        = swap ? mirror_lanes(core_be) : core_be;
    bus_wdata_o = swap ? mirror_bytes(core_data) : core_data;
  end

endmodule

// File: rtl/endian_rd_lanes.sv
module endian_rd_lanes
  import endian_pkg::*;
(
  input  order_e           mode_i,
  input  size_e            size_i,
  input  logic [1:0]       lane_off_i,
  input  logic [BUS_W-1:0] bus_rdata_i,
  output logic [BUS_W-1:0] rdata_o
);

  logic [BUS_W-1:0] core_lanes;

  always_comb begin
    core_lanes = (mode_i == ORD_TRUE_LE) ? mirror_bytes(bus_rdata_i) : bus_rdata_i;
    rdata_o    = pick_msb_first(core_lanes, size_i, lane_off_i);
  end

endmodule

// File: rtl/endian_bus_adapter.sv
module endian_bus_adapter
  import endian_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_we_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              align_err_o,
  output logic              bus_valid_o,
  input  logic              bus_ready_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [3:0]        bus_be_o,
  output logic              bus_we_o,
  output logic [31:0]       bus_wdata_o,
  input  logic [31:0]       bus_rdata_i
);

  order_e mode_in, mode_q;
  size_e  size_in, size_q;
  logic [1:0] off_q;
  logic       busy_q;

  logic [ADDR_W-1:0] map_addr;
  logic [1:0]        map_off;
  logic              map_misalign;
  logic [LANES-1:0]  wr_be;
  logic [BUS_W-1:0]  wr_data;
  logic [BUS_W-1:0]  rd_data;

  // named events for the checker
  logic accept, err_fire, issue, done;

  assign mode_in = order_e'(mode_i);
  assign size_in = size_e'(req_size_i);

  assign req_ready_o = !busy_q;
  assign bus_valid_o = busy_q;
  assign accept      = req_valid_i && !busy_q;
  assign err_fire    = accept && map_misalign;
  assign issue       = accept && !map_misalign;
  assign done        = busy_q && bus_ready_i;

  endian_addr_map #(.ADDR_W(ADDR_W)) u_addr (
    .addr_i    (req_addr_i),
    .size_i    (size_in),
    .mode_i    (mode_in),
    .bus_addr_o(map_addr),
    .lane_off_o(map_off),
    .misalign_o(map_misalign)
  );

  endian_wr_lanes u_wr (
    .mode_i     (mode_in),
    .size_i     (size_in),
    .lane_off_i (map_off),
    .wdata_i    (req_wdata_i),
    .be_o       (wr_be),
    .bus_wdata_o(wr_data)
  );

  endian_rd_lanes u_rd (
    .mode_i     (mode_q),
    .size_i     (size_q),
    .lane_off_i (off_q),
    .bus_rdata_i(bus_rdata_i),
    .rdata_o    (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      mode_q      <= ORD_BIG;
      size_q      <= SZ_BYTE;
      off_q       <= 2'b00;
      bus_addr_o  <= '0;
      bus_be_o    <= '0;
      bus_we_o    <= 1'b0;
      bus_wdata_o <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      align_err_o <= 1'b0;
    end else begin
      align_err_o <= err_fire;
      rsp_valid_o <= done;
      if (issue) begin
        busy_q      <= 1'b1;
        mode_q      <= mode_in;
        size_q      <= size_in;
        off_q       <= map_off;
        bus_addr_o  <= map_addr;
        bus_be_o    <= wr_be;
        bus_we_o    <= req_we_i;
        bus_wdata_o <= wr_data;
      end else if (done) begin
        busy_q      <= 1'b0;
        rsp_rdata_o <= bus_we_o ? '0 : rd_data;
      end
    end
  end

endmodule

// File: rtl/endian_bus_adapter_chk.sv
module endian_bus_adapter_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              err_fire,
  input logic              issue,
  input logic              done,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              align_err_o,
  input logic              bus_valid_o,
  input logic              bus_ready_i,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [3:0]        bus_be_o,
  input logic [31:0]       bus_wdata_o
);

  assert_err_no_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_fire |=> align_err_o && !bus_valid_o);

  assert_issue_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> bus_valid_o);

  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && !bus_ready_i) |=>
      (bus_valid_o && $stable(bus_addr_o) && $stable(bus_be_o) && $stable(bus_wdata_o)));

  assert_rsp_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rsp_valid_o && !bus_valid_o);

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o |-> !req_ready_o);

  assert_lane_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o |-> ($countones(bus_be_o) == 1 || $countones(bus_be_o) == 2 ||
                     $countones(bus_be_o) == 4));

endmodule

bind endian_bus_adapter endian_bus_adapter_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .err_fire   (err_fire),
  .issue      (issue),
  .done       (done),
  .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o),
  .align_err_o(align_err_o),
  .bus_valid_o(bus_valid_o),
  .bus_ready_i(bus_ready_i),
  .bus_addr_o (bus_addr_o),
  .bus_be_o   (bus_be_o),
  .bus_wdata_o(bus_wdata_o)
);

// File: tb/endian_bus_adapter_tb_top.sv
`timescale 1ns/1ps
module endian_bus_adapter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_size_i = 2'b00;
  logic        req_we_i = 1'b0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic        align_err_o;
  logic        bus_valid_o;
  logic        bus_ready_i = 1'b1;
  logic [31:0] bus_addr_o;
  logic [3:0]  bus_be_o;
  logic        bus_we_o;
  logic [31:0] bus_wdata_o;
  logic [31:0] bus_rdata_i;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  endian_bus_adapter #(.ADDR_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_addr_i(req_addr_i),
    .req_size_i(req_size_i), .req_we_i(req_we_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .align_err_o(align_err_o),
    .bus_valid_o(bus_valid_o), .bus_ready_i(bus_ready_i), .bus_addr_o(bus_addr_o),
    .bus_be_o(bus_be_o), .bus_we_o(bus_we_o), .bus_wdata_o(bus_wdata_o),
    .bus_rdata_i(bus_rdata_i)
  );

  // memory model: byte offset k of a word lives in bits [31-8k -: 8]
  logic [31:0] mem [8];
  initial for (int i = 0; i < 8; i++) mem[i] = '0;
  assign bus_rdata_i = mem[bus_addr_o[4:2]];
  always @(posedge clk) begin
    if (bus_valid_o && bus_ready_i && bus_we_o)
      for (int k = 0; k < 4; k++)
        if (bus_be_o[k]) mem[bus_addr_o[4:2]][31-8*k -: 8] <= bus_wdata_o[31-8*k -: 8];
  end

  logic [31:0] got_rd, got_ba, got_bw;
  logic [3:0]  got_be;
  logic        got_err, got_bus;

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] md, input logic [31:0] addr, input logic [1:0] sz,
                        input logic we, input logic [31:0] wd, input bit stall);
    got_rd = 'x; got_ba = 'x; got_bw = 'x; got_be = 'x; got_err = 0; got_bus = 0;
    @(negedge clk);
    mode_i = md; req_addr_i = addr; req_size_i = sz; req_we_i = we; req_wdata_i = wd;
    req_valid_i = 1'b1;
    if (stall) bus_ready_i = 1'b0;
    @(negedge clk);
    req_valid_i = 1'b0;
    for (int n = 0; n < 20; n++) begin
      if (align_err_o) begin got_err = 1; break; end
      if (rsp_valid_o) begin got_rd = rsp_rdata_o; break; end
      if (bus_valid_o) begin
        got_bus = 1; got_ba = bus_addr_o; got_be = bus_be_o; got_bw = bus_wdata_o;
      end
      if (stall && n == 0) mode_i = (md == 2'b00) ? 2'b01 : 2'b00;
      if (stall && n == 3) bus_ready_i = 1'b1;
      @(negedge clk);
    end
    bus_ready_i = 1'b1;
  endtask

  task automatic t_reset;
    check("R10", "req_ready", {31'b0, req_ready_o}, 32'd1);
    check("R10", "bus_valid", {31'b0, bus_valid_o}, 32'd0);
    check("R10", "rsp_valid", {31'b0, rsp_valid_o}, 32'd0);
    check("R10", "align_err", {31'b0, align_err_o}, 32'd0);
  endtask

  task automatic t_big;
    access(2'b00, 32'd0, 2'b10, 1'b1, 32'h11223344, 0);
    check("R2", "BE word addr", got_ba, 32'd0);
    check("R2", "BE word data", got_bw, 32'h11223344);
    check("R5", "BE word be", {28'b0, got_be}, 32'hF);
    check("R6", "write rsp data", got_rd, 32'h0);
    access(2'b00, 32'd0, 2'b00, 1'b0, 0, 0);
    check("R2", "BE byte0 read", got_rd, 32'h11);
    access(2'b00, 32'd3, 2'b00, 1'b0, 0, 0);
    check("R6", "BE byte3 read", got_rd, 32'h44);
    check("R5", "BE byte3 be", {28'b0, got_be}, 32'h8);
    access(2'b00, 32'd2, 2'b01, 1'b0, 0, 0);
    check("R6", "BE half2 read", got_rd, 32'h3344);
    check("R5", "BE half2 be", {28'b0, got_be}, 32'hC);
    access(2'b00, 32'd1, 2'b00, 1'b1, 32'hFFFFFF5A, 0);
    check("R2", "BE byte1 wdata", got_bw, 32'h005A0000);
    access(2'b00, 32'd0, 2'b10, 1'b0, 0, 0);
    check("R2", "BE word after byte write", got_rd, 32'h115A3344);
  endtask

  task automatic t_true_le;
    access(2'b01, 32'd8, 2'b10, 1'b1, 32'hAABBCCDD, 0);
    check("R3", "TLE word addr", got_ba, 32'd8);
    check("R3", "TLE word bus data", got_bw, 32'hDDCCBBAA);
    access(2'b00, 32'd8, 2'b10, 1'b0, 0, 0);
    check("R3", "physical layout via BE read", got_rd, 32'hDDCCBBAA);
    access(2'b01, 32'd9, 2'b00, 1'b0, 0, 0);
    check("R3", "TLE byte9 read", got_rd, 32'hCC);
    check("R3", "TLE byte9 be", {28'b0, got_be}, 32'h2);
    check("R3", "TLE byte9 addr", got_ba, 32'd9);
    access(2'b01, 32'd10, 2'b01, 1'b0, 0, 0);
    check("R6", "TLE half10 read", got_rd, 32'hAABB);
    access(2'b01, 32'd14, 2'b01, 1'b1, 32'h00001234, 0);
    check("R3", "TLE half14 data", got_bw, 32'h00003412);
    check("R3", "TLE half14 be", {28'b0, got_be}, 32'hC);
    access(2'b01, 32'd12, 2'b10, 1'b0, 0, 0);
    check("R3", "TLE word12 read", got_rd, 32'h12340000);
  endtask

  task automatic t_munged;
    access(2'b10, 32'd16, 2'b10, 1'b1, 32'h01020304, 0);
    check("R4", "munged word addr", got_ba, 32'd20);
    check("R4", "munged word data", got_bw, 32'h01020304);
    access(2'b10, 32'd16, 2'b00, 1'b0, 0, 0);
    check("R4", "munged byte16 addr", got_ba, 32'd23);
    check("R4", "munged byte16 read", got_rd, 32'h04);
    access(2'b10, 32'd18, 2'b01, 1'b0, 0, 0);
    check("R4", "munged half18 addr", got_ba, 32'd20);
    check("R4", "munged half18 read", got_rd, 32'h0102);
    access(2'b10, 32'd21, 2'b00, 1'b1, 32'h00000077, 0);
    check("R4", "munged byte21 addr", got_ba, 32'd18);
    check("R5", "munged byte21 be", {28'b0, got_be}, 32'h4);
    check("R4", "munged byte21 data", got_bw, 32'h00007700);
    access(2'b10, 32'd20, 2'b10, 1'b0, 0, 0);
    check("R4", "munged word20 addr", got_ba, 32'd16);
    check("R4", "munged word20 read", got_rd, 32'h00007700);
  endtask

  task automatic t_align;
    access(2'b00, 32'd1, 2'b01, 1'b0, 0, 0);
    check("R7", "half@1 err", {31'b0, got_err}, 32'd1);
    check("R7", "half@1 no bus", {31'b0, got_bus}, 32'd0);
    access(2'b10, 32'd2, 2'b10, 1'b1, 32'hDEADBEEF, 0);
    check("R7", "word@2 err", {31'b0, got_err}, 32'd1);
    check("R7", "word@2 no bus", {31'b0, got_bus}, 32'd0);
    access(2'b01, 32'd0, 2'b11, 1'b0, 0, 0);
    check("R7", "bad size err", {31'b0, got_err}, 32'd1);
    @(negedge clk);
    check("R7", "err pulse one cycle", {31'b0, align_err_o}, 32'd0);
    check("R7", "ready after err", {31'b0, req_ready_o}, 32'd1);
  endtask

  task automatic t_mode_hold;
    access(2'b01, 32'd8, 2'b10, 1'b0, 0, 1);
    check("R8", "stalled TLE read under mode flip", got_rd, 32'hAABBCCDD);
    check("R8", "stalled addr", got_ba, 32'd8);
    check("R9", "response after stall", {31'b0, got_bus}, 32'd1);
  endtask

  task automatic t_rsvd;
    access(2'b11, 32'd0, 2'b00, 1'b0, 0, 0);
    check("R1", "reserved mode acts BE", got_rd, 32'h11);
    check("R1", "reserved mode addr", got_ba, 32'd0);
  endtask

  initial begin
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_big;
    t_true_le;
    t_munged;
    t_align;
    t_mode_hold;
    t_rsvd;
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule